// File: doc/BRIEF.md
# Owned-Pin GPIO Bank with Edge Interrupts

This block is a bank of general-purpose pins behind a small word-wide register bus. Software sets which pins this side owns, which owned pins drive, and the level each owned pin drives. It can read the sampled pin levels at any time. Pin inputs pass through a two-flop synchronizer. Every pin has a detector that watches one edge. The edge it watches is chosen per pin, rising or falling.

A detected edge sets the pin's bit in a sticky status register. This happens whether or not the pin's mask bit is set. The unmasked status bits are ORed into a single level interrupt. A build-time parameter picks how software acknowledges status. In one setting, software writes ones to the bits it wants cleared. In the other, reading the status word empties it. A pin that this side does not own never drives, whatever its data and direction bits hold.

Top module: `gpio_owned_bank`

## Requirements
- R1: After reset, all mask bits are 1 and every other register is 0. Status, output data, direction, edge select and ownership therefore read 0. `irq`, `pin_oe` and `pin_out` are all 0.
- R2: The register offsets are 0x00 sampled input, 0x04 output level, 0x08 direction, 0x0C edge select, 0x10 mask, 0x14 status and 0x18 ownership. Bit i of each register belongs to pin i. Read data is zero above the pin count. Any other offset reads 0. Writes to the input register have no effect.
- R3: The input register shows `pin_in` two clock edges after it is sampled. A value set up before edge k reads back after edge k+1 and not after edge k.
- R4: Ownership bit 1 hands the pin to this side. Direction bit 1 makes a pin an input and 0 makes it an output. `pin_oe` is 1 only for an owned output pin. `pin_out` carries the output-level bit only for owned pins and is 0 for pins that are not owned.
- R5: Edge-select bit 1 detects rising edges and 0 detects falling edges of the synchronized input. A detected edge sets its status bit even while its mask bit is 1. An edge of the other polarity leaves status unchanged.
- R6: `irq` is 1 exactly when some status bit is 1 and its mask bit is 0.
- R7: With the write-clear setting, a write to the status offset clears each status bit whose data bit is 1. The other bits are kept.
- R8: With the clear-on-read setting, a status read returns the current status and clears all bits after that cycle. Writes to the status offset have no effect.
- R9: If an edge is detected in the same cycle its status bit is being cleared, the bit stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe; only the status clear-on-read setting uses it |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 16 | Raw pin levels |
| pin_out | output | 16 | Driven pin levels |
| pin_oe | output | 16 | Per-pin output enable |
| irq | output | 1 | Bank interrupt, level |

## Verification
A wrong ownership or direction bit shows at `pin_oe` or `pin_out` on the cycle after the write. A lost or stuck status bit shows on `irq` once the mask is opened, and on the next status read. A synchronizer of the wrong depth is exposed by reading the input register one edge early and one edge late. The same-cycle race between an edge and a clear is driven on the exact cycle, for both clear settings. A wrong priority then leaves a status bit missing on the following read.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    localparam logic [7:0] OFS_IN   = 8'h00;
    localparam logic [7:0] OFS_OUT  = 8'h04;
    localparam logic [7:0] OFS_DIR  = 8'h08;
    localparam logic [7:0] OFS_EDGE = 8'h0C;
    localparam logic [7:0] OFS_MASK = 8'h10;
    localparam logic [7:0] OFS_STAT = 8'h14;
    localparam logic [7:0] OFS_OWN  = 8'h18;

    typedef enum logic [0:0] {
        CLR_WRITE_ONE = 1'b0,
        CLR_ON_READ   = 1'b1
    } clr_mode_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] cur_o,
    output logic [N-1:0] prev_o
);
    typedef struct packed {
        logic [N-1:0] meta;
        logic [N-1:0] cur;
        logic [N-1:0] prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.meta = pin_i;
        s_d.cur  = s_q.meta;
        s_d.prev = s_q.cur;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cur_o  = s_q.cur;
    assign prev_o = s_q.prev;
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
    parameter int N = 16
) (
    input  logic [N-1:0] cur_i,
    input  logic [N-1:0] prev_i,
    input  logic [N-1:0] rise_sel_i,
    output logic [N-1:0] evt_o
);
    for (genvar i = 0; i < N; i++) begin : g_pin
        logic rise_w, fall_w;
        assign rise_w   = cur_i[i] & ~prev_i[i];
        assign fall_w   = ~cur_i[i] & prev_i[i];
        assign evt_o[i] = rise_sel_i[i] ? rise_w : fall_w;
    end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_bank_pkg::*;
#(
    parameter int        N        = 16,
    parameter int        ADDR_W   = 8,
    parameter int        DATA_W   = 32,
    parameter clr_mode_e CLR_MODE = CLR_WRITE_ONE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N-1:0]      sync_in_i,
    input  logic [N-1:0]      edge_evt_i,
    output logic [N-1:0]      dout_o,
    output logic [N-1:0]      dir_o,
    output logic [N-1:0]      rise_sel_o,
    output logic [N-1:0]      own_o,
    output logic              irq_o
);
    localparam logic [ADDR_W-1:0] A_IN   = ADDR_W'(OFS_IN);
    localparam logic [ADDR_W-1:0] A_OUT  = ADDR_W'(OFS_OUT);
    localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFS_DIR);
    localparam logic [ADDR_W-1:0] A_EDGE = ADDR_W'(OFS_EDGE);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_OWN  = ADDR_W'(OFS_OWN);

    typedef struct packed {
        logic [N-1:0] dout;
        logic [N-1:0] dir;
        logic [N-1:0] rise;
        logic [N-1:0] mask;
        logic [N-1:0] stat;
        logic [N-1:0] own;
    } regs_t;

    regs_t        r_d, r_q;
    logic [N-1:0] clr_vec;
    logic         stat_hit;
    logic         unused_bits;

    assign stat_hit    = (bus_addr == A_STAT);
    assign unused_bits = ^{bus_wdata[DATA_W-1:N], bus_re};

    if (CLR_MODE == CLR_ON_READ) begin : g_clr_read
        assign clr_vec = (bus_re && stat_hit) ? '1 : '0;
    end else begin : g_clr_write
        assign clr_vec = (bus_we && stat_hit) ? bus_wdata[N-1:0] : '0;
    end

    always_comb begin
        r_d = r_q;
        if (bus_we) begin
            case (bus_addr)
                A_OUT:   r_d.dout = bus_wdata[N-1:0];
                A_DIR:   r_d.dir  = bus_wdata[N-1:0];
                A_EDGE:  r_d.rise = bus_wdata[N-1:0];
                A_MASK:  r_d.mask = bus_wdata[N-1:0];
                A_OWN:   r_d.own  = bus_wdata[N-1:0];
                default: ;
            endcase
        end
        r_d.stat = (r_q.stat & ~clr_vec) | edge_evt_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.mask <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_IN:    bus_rdata[N-1:0] = sync_in_i;
            A_OUT:   bus_rdata[N-1:0] = r_q.dout;
            A_DIR:   bus_rdata[N-1:0] = r_q.dir;
            A_EDGE:  bus_rdata[N-1:0] = r_q.rise;
            A_MASK:  bus_rdata[N-1:0] = r_q.mask;
            A_STAT:  bus_rdata[N-1:0] = r_q.stat;
            A_OWN:   bus_rdata[N-1:0] = r_q.own;
            default: bus_rdata = '0;
        endcase
    end

    assign dout_o     = r_q.dout;
    assign dir_o      = r_q.dir;
    assign rise_sel_o = r_q.rise;
    assign own_o      = r_q.own;
    assign irq_o      = |(r_q.stat & ~r_q.mask);

    // R7 R8
    stat_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(r_q.stat) & ~r_q.stat) & ~$past(clr_vec)) == '0));

    // R9
    edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(edge_evt_i) & ~r_q.stat) == '0));
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
    parameter int N = 16
) (
    input  logic [N-1:0] own_i,
    input  logic [N-1:0] dir_i,
    input  logic [N-1:0] dout_i,
    output logic [N-1:0] pin_out_o,
    output logic [N-1:0] pin_oe_o
);
    for (genvar i = 0; i < N; i++) begin : g_pad
        assign pin_oe_o[i]  = own_i[i] & ~dir_i[i];
        assign pin_out_o[i] = own_i[i] & dout_i[i];
    end
endmodule

// File: rtl/gpio_owned_bank.sv
module gpio_owned_bank
    import gpio_bank_pkg::*;
#(
    parameter int        N_PINS   = 16,
    parameter int        ADDR_W   = 8,
    parameter int        DATA_W   = 32,
    parameter clr_mode_e CLR_MODE = CLR_WRITE_ONE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_PINS-1:0] pin_in,
    output logic [N_PINS-1:0] pin_out,
    output logic [N_PINS-1:0] pin_oe,
    output logic              irq
);
    logic [N_PINS-1:0] cur_w, prev_w, evt_w, dout_w, dir_w, rise_w, own_w;

    gpio_in_sync #(.N(N_PINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_in), .cur_o(cur_w), .prev_o(prev_w)
    );

    gpio_edge_det #(.N(N_PINS)) u_edge (
        .cur_i(cur_w), .prev_i(prev_w), .rise_sel_i(rise_w), .evt_o(evt_w)
    );

    gpio_regs #(.N(N_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLR_MODE(CLR_MODE)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sync_in_i(cur_w), .edge_evt_i(evt_w),
        .dout_o(dout_w), .dir_o(dir_w), .rise_sel_o(rise_w), .own_o(own_w), .irq_o(irq)
    );

    gpio_pad_ctrl #(.N(N_PINS)) u_pad (
        .own_i(own_w), .dir_i(dir_w), .dout_i(dout_w), .pin_out_o(pin_out), .pin_oe_o(pin_oe)
    );

    // R4
    oe_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe & ~own_w) == '0));

    // R4
    out_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out & ~own_w) == '0));
endmodule

// File: tb/sim_gpio_owned_bank.sv
`timescale 1ns/1ps
module sim_gpio_owned_bank;
    import gpio_bank_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [15:0] pin_in = '0;
    logic [31:0] rd0, rd1;
    logic [15:0] pout0, poe0, pout1, poe1;
    logic        irq0, irq1;

    always #2.5 clk = ~clk;

    gpio_owned_bank #(.CLR_MODE(CLR_WRITE_ONE)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
        .bus_wdata(bus_wdata), .bus_rdata(rd0), .pin_in(pin_in), .pin_out(pout0),
        .pin_oe(poe0), .irq(irq0));

    gpio_owned_bank #(.CLR_MODE(CLR_ON_READ)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
        .bus_wdata(bus_wdata), .bus_rdata(rd1), .pin_in(pin_in), .pin_out(pout1),
        .pin_oe(poe1), .irq(irq1));

    int n_chk = 0;
    int n_err = 0;
    logic [15:0] m_out, m_dir, m_edge, m_mask, m_own, m_in, st_w, st_r;

    function automatic logic [31:0] exp_read(input logic [7:0] a, input logic [15:0] st);
        case (a)
            OFS_IN:   return {16'h0, m_in};
            OFS_OUT:  return {16'h0, m_out};
            OFS_DIR:  return {16'h0, m_dir};
            OFS_EDGE: return {16'h0, m_edge};
            OFS_MASK: return {16'h0, m_mask};
            OFS_STAT: return {16'h0, st};
            OFS_OWN:  return {16'h0, m_own};
            default:  return 32'h0;
        endcase
    endfunction

    function automatic logic [15:0] exp_evt(input logic [15:0] old_v, input logic [15:0] new_v);
        return (m_edge & new_v & ~old_v) | (~m_edge & ~new_v & old_v);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        #1 bus_we = 1'b0;
        case (a)
            OFS_OUT:  m_out  = d[15:0];
            OFS_DIR:  m_dir  = d[15:0];
            OFS_EDGE: m_edge = d[15:0];
            OFS_MASK: m_mask = d[15:0];
            OFS_OWN:  m_own  = d[15:0];
            OFS_STAT: st_w   = st_w & ~d[15:0];
            default: ;
        endcase
    endtask

    task automatic bus_read(input string req, input logic [7:0] a);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        #1;
        chk({req, " wr1c"}, rd0, exp_read(a, st_w));
        chk({req, " rdclr"}, rd1, exp_read(a, st_r));
        @(posedge clk);
        #1 bus_re = 1'b0;
        if (a == OFS_STAT) st_r = '0;
    endtask

    task automatic set_pins(input logic [15:0] v);
        logic [15:0] evt;
        @(negedge clk);
        pin_in = v;
        evt = exp_evt(m_in, v);
        repeat (4) @(posedge clk);
        st_w |= evt; st_r |= evt; m_in = v;
    endtask

    task automatic check_outs(input string req);
        @(negedge clk);
        chk({req, " oe"},  {16'h0, poe0},  {16'h0, m_own & ~m_dir});
        chk({req, " out"}, {16'h0, pout0}, {16'h0, m_own & m_out});
        chk({req, " oe1"}, {16'h0, poe1},  {16'h0, m_own & ~m_dir});
        chk({req, " out1"},{16'h0, pout1}, {16'h0, m_own & m_out});
        chk("R6 irq wr1c",  {31'h0, irq0}, {31'h0, |(st_w & ~m_mask)});
        chk("R6 irq rdclr", {31'h0, irq1}, {31'h0, |(st_r & ~m_mask)});
    endtask

    initial begin : watchdog
        #(200000 * 5);
        n_err++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin : main
        logic [15:0] p;
        void'($urandom(32'h5EED_0042));
        m_out = '0; m_dir = '0; m_edge = '0; m_mask = 16'hFFFF; m_own = '0;
        m_in = '0; st_w = '0; st_r = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset values, R2 map and unused offset
        for (int i = 0; i < 8; i++) bus_read("R1 R2 reset", 8'(i * 4));
        check_outs("R1 reset");

        // R4 ownership and direction
        bus_write(OFS_OWN, 32'h0000_00FF);
        bus_write(OFS_DIR, 32'h0000_0F0F);
        bus_write(OFS_OUT, 32'h0000_AAAA);
        check_outs("R4 owned");
        chk("R4 oe value", {16'h0, poe0}, 32'h0000_00F0);
        chk("R4 out value", {16'h0, pout0}, 32'h0000_00AA);

        // R2 input register ignores writes
        bus_write(OFS_IN, 32'hFFFF_FFFF);
        bus_read("R2 in ro", OFS_IN);

        // R3 synchronizer latency
        @(negedge clk) pin_in = 16'h1234;
        @(posedge clk);
        @(negedge clk) bus_addr = OFS_IN;
        #1 chk("R3 early", rd0, 32'h0);
        @(posedge clk);
        @(negedge clk);
        #1 chk("R3 ready", rd0, 32'h0000_1234);
        repeat (2) @(posedge clk);
        st_w |= exp_evt(m_in, 16'h1234); st_r |= exp_evt(m_in, 16'h1234); m_in = 16'h1234;

        // R5 edges set status while masked
        bus_write(OFS_EDGE, 32'h0000_00FF);
        set_pins(16'h12CB);
        bus_read("R5 stat", OFS_STAT);
        check_outs("R5 masked");
        bus_write(OFS_MASK, 32'h0000_0000);
        set_pins(16'h0F0F);
        check_outs("R6 unmasked");

        // R7 partial write clear
        bus_write(OFS_STAT, 32'h0000_0101);
        bus_read("R7 partial", OFS_STAT);
        bus_read("R8 after read", OFS_STAT);

        // R9 edge meets clear on the same cycle
        bus_write(OFS_EDGE, 32'h0000_0001);
        set_pins(m_in & ~16'h1);
        set_pins(m_in | 16'h1);
        set_pins(m_in & ~16'h1);
        p = m_in | 16'h1;
        @(negedge clk) pin_in = p;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        bus_addr = OFS_STAT; bus_wdata = 32'hFFFF_FFFF; bus_we = 1'b1; bus_re = 1'b1;
        #1 chk("R9 read in race", rd1, exp_read(OFS_STAT, st_r));
        @(posedge clk);
        #1 bus_we = 1'b0; bus_re = 1'b0;
        st_w = exp_evt(m_in, p); st_r = exp_evt(m_in, p); m_in = p;
        bus_read("R9 edge wins", OFS_STAT);
        chk("R9 bit0 kept", rd0 & 32'h1, 32'h1);

        // R8 write to status ignored in clear-on-read
        set_pins(m_in & ~16'h1);
        set_pins(m_in | 16'h1);
        bus_write(OFS_STAT, 32'hFFFF_FFFF);
        bus_read("R8 write ignored", OFS_STAT);

        // Random mix
        for (int n = 0; n < 400; n++) begin
            case ($urandom % 4)
                0: bus_write(8'(($urandom % 8) * 4), $urandom);
                1: bus_read("R2 R7 R8 random", 8'(($urandom % 8) * 4));
                2: set_pins(16'($urandom));
                default: check_outs("R4 R6 random");
            endcase
        end
        check_outs("R4 R6 final");

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule